// File: doc/BRIEF.md
# APB Requester with Per-Command Idle Gap

This block turns single requests from a valid/ready command port into APB transfers. A request holds a 32-bit address, a direction bit, 32-bit write data and a 3-bit idle-gap field. Once the block accepts a request, it runs a setup cycle and then an access phase. The access phase lasts until the target raises PREADY. The block then returns the read data and the target's error flag on a response port as a single-cycle strobe.

The gap field sets how many cycles the requester must rest after each completed transfer before it takes the next command. The same requester can therefore pace slow peripherals one command at a time. A value above five is treated as five.

The control is a four-state machine:

- `ST_IDLE` is waiting for a command.
- `ST_SETUP` has select high and enable low.
- `ST_ACCESS` has select and enable high.
- `ST_GAP` is the rest countdown.

Its transitions are:

- `ST_IDLE`→`ST_SETUP` on an accepted command.
- `ST_SETUP`→`ST_ACCESS` unconditionally.
- `ST_ACCESS`→`ST_ACCESS` while PREADY is low.
- `ST_ACCESS`→`ST_IDLE` on PREADY with a zero gap.
- `ST_ACCESS`→`ST_GAP` on PREADY with a non-zero gap.
- `ST_GAP`→`ST_IDLE` when the countdown reaches its last cycle.

Top module: `apb_gap_requester`

## Requirements
- R1: When `cmd_valid` and `cmd_ready` are both high at a clock edge, the next cycle is a setup cycle. In it `psel`=1, `penable`=0, `paddr` equals the command address and `pwrite` equals the command direction (1 = write). `pwdata` carries the write data for a write and is all zeros for a read.
- R2: The cycle after a setup cycle has `psel`=1 and `penable`=1.
- R3: The access phase lasts as long as `pready` is sampled low, with `paddr`, `pwrite` and `pwdata` stable. It therefore spans exactly W+1 cycles when the target inserts W wait cycles.
- R4: After the edge at which `pready` is sampled high in the access phase, `psel` and `penable` are both low.
- R5: `rsp_valid` is high for exactly one cycle, the cycle after completion. In that cycle `rsp_rdata` holds `prdata` sampled at completion for a read and zero for a write, and `rsp_err` holds `pslverr` sampled at completion.
- R6: `cmd_ready` is high only while the requester is idle with no gap counting down. A command presented while `cmd_ready` is low starts no transfer (`psel` stays low).
- R7: After completion, `cmd_ready` stays low for exactly G cycles and then rises. G is the 3-bit gap field of that command, with 6 and 7 treated as 5.
- R8: While `rst_n` is low, `psel`, `penable` and `rsp_valid` are low and `cmd_ready` is high. An active transfer is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_addr | input | 32 | Transfer address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 32 | Write data |
| cmd_gap | input | 3 | Idle cycles after the transfer (0..5, larger clamps to 5) |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_err | output | 1 | Captured target error flag |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| paddr | output | 32 | APB address |
| pwrite | output | 1 | APB direction |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB target ready |
| pslverr | input | 1 | APB target error |

## Verification
The bound checker watches the handshake on every cycle:

- The setup cycle follows acceptance.
- Enable rises after setup and the bus stays stable through wait states.
- The bus is released after `pready`.
- The response is a single-cycle pulse.
- `cmd_ready` never coincides with an active select.
- Reset forces the bus idle.

Only the bench's sweep over every gap code (including the clamped 6 and 7), wait counts 0 to 3, both directions and both error values can show several things. These are the exact length of the rest period, the W+1 length of the access phase, and the correct read data or zero in the response. Only its mid-transfer reset scenario shows that a transfer is abandoned.

// File: rtl/apb_req_pkg.sv
package apb_req_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_GAP    = 2'd3
    } req_state_t;

    function automatic int unsigned gap_width(input int unsigned max_gap);
        return (max_gap < 2) ? 1 : $clog2(max_gap + 1);
    endfunction

endpackage

// File: rtl/apb_cmd_hold.sv
module apb_cmd_hold #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned GAP_W   = 3,
    parameter int unsigned GAP_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [GAP_W-1:0]  in_gap,
    output logic [ADDR_W-1:0] hold_addr,
    output logic              hold_write,
    output logic [DATA_W-1:0] hold_wdata,
    output logic [GAP_W-1:0]  hold_gap
);
    localparam logic [GAP_W-1:0] GAP_LIMIT = GAP_W'(GAP_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_write <= 1'b0;
            hold_wdata <= '0;
            hold_gap   <= '0;
        end else if (capture) begin
            hold_addr  <= in_addr;
            hold_write <= in_write;
            // reads put zeros on the write-data lines
            hold_wdata <= in_write ? in_wdata : '0;
            hold_gap   <= (in_gap > GAP_LIMIT) ? GAP_LIMIT : in_gap;
        end
    end
endmodule

// File: rtl/apb_gap_timer.sv
module apb_gap_timer #(
    parameter int unsigned GAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             last
);
    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == GAP_W'(1));
endmodule

// File: rtl/apb_rsp_reg.sv
module apb_rsp_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              is_read,
    input  logic [DATA_W-1:0] rd_in,
    input  logic              err_in,
    output logic              valid,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            valid <= done;
            if (done) begin
                rdata <= is_read ? rd_in : '0;
                err   <= err_in;
            end
        end
    end
endmodule

// File: rtl/apb_gap_requester.sv
module apb_gap_requester
    import apb_req_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned GAP_MAX = 5,
    parameter int unsigned GAP_W   = gap_width(GAP_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [GAP_W-1:0]  cmd_gap,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              psel,
    output logic              penable,
    output logic [ADDR_W-1:0] paddr,
    output logic              pwrite,
    output logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pready,
    input  logic              pslverr
);
    req_state_t       state_q, state_d;
    logic             accept, done, gap_last;
    logic [GAP_W-1:0] hold_gap;

    assign accept = cmd_valid && cmd_ready;
    assign done   = (state_q == ST_ACCESS) && pready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ACCESS;
            ST_ACCESS: if (pready) state_d = (hold_gap == '0) ? ST_IDLE : ST_GAP;
            ST_GAP:    if (gap_last) state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        cmd_ready = 1'b0;
        psel      = 1'b0;
        penable   = 1'b0;
        unique case (state_q)
            ST_IDLE:   cmd_ready = 1'b1;
            ST_SETUP:  psel = 1'b1;
            ST_ACCESS: begin psel = 1'b1; penable = 1'b1; end
            ST_GAP:    ;
        endcase
    end

    apb_cmd_hold #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_W(GAP_W), .GAP_MAX(GAP_MAX)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .capture(accept),
        .in_addr(cmd_addr), .in_write(cmd_write), .in_wdata(cmd_wdata), .in_gap(cmd_gap),
        .hold_addr(paddr), .hold_write(pwrite), .hold_wdata(pwdata), .hold_gap(hold_gap)
    );

    apb_gap_timer #(.GAP_W(GAP_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(done), .load_val(hold_gap), .last(gap_last)
    );

    apb_rsp_reg #(.DATA_W(DATA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .done(done), .is_read(!pwrite),
        .rd_in(prdata), .err_in(pslverr),
        .valid(rsp_valid), .rdata(rsp_rdata), .err(rsp_err)
    );
endmodule

// File: rtl/apb_gap_requester_chk.sv
module apb_gap_requester_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_write,
    input logic              rsp_valid,
    input logic              psel,
    input logic              penable,
    input logic [ADDR_W-1:0] paddr,
    input logic              pwrite,
    input logic [DATA_W-1:0] pwdata,
    input logic              pready
);
    p_setup_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> psel && !penable
            && paddr == $past(cmd_addr) && pwrite == $past(cmd_write));

    p_read_zero_wdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !pwrite |-> pwdata == '0);

    p_enable_after_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !penable |=> psel && penable);

    p_wait_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !pready |=> psel && penable
            && $stable(paddr) && $stable(pwrite) && $stable(pwdata));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pready |=> !psel && !penable);

    p_rsp_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pready |=> rsp_valid);

    p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_ready_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !psel && !penable);

    p_reset_idle_r8: assert property (@(posedge clk)
        !rst_n |-> !psel && !penable && !rsp_valid && cmd_ready);
endmodule

bind apb_gap_requester apb_gap_requester_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .rsp_valid(rsp_valid),
    .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
    .pwdata(pwdata), .pready(pready)
);

// File: tb/apb_gap_requester_tb_top.sv
`timescale 1ns/1ps
module apb_gap_requester_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [2:0]  cmd_gap = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        psel, penable, pwrite;
    logic [31:0] paddr, pwdata;
    logic [31:0] prdata = '0;
    logic        pready = 1'b0;
    logic        pslverr = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int tgt_ws = 0;
    bit tgt_err = 1'b0;
    int acc_cnt = 0;

    always #2 clk = ~clk;

    apb_gap_requester dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .cmd_gap(cmd_gap),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    function automatic logic [31:0] tgt_data(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    // target model: W wait cycles then ready
    always @(negedge clk) begin
        if (psel && penable) begin
            pready  <= (acc_cnt == tgt_ws);
            acc_cnt <= acc_cnt + 1;
        end else begin
            pready  <= 1'b0;
            acc_cnt <= 0;
        end
        prdata  <= tgt_data(paddr);
        pslverr <= tgt_err && psel && penable;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_xfer(input logic [31:0] a, input bit w, input logic [31:0] d,
                           input int g, input int ws, input bit e);
        int n;
        int cnt;
        int exp_g;
        logic [31:0] exp_wd;
        exp_g  = (g > 5) ? 5 : g;
        exp_wd = w ? d : 32'h0;
        tgt_ws = ws;
        tgt_err = e;
        while (!cmd_ready) @(negedge clk);
        cmd_addr = a; cmd_write = w; cmd_wdata = d; cmd_gap = 3'(g);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(psel && !penable, "R1 setup phase", {30'b0, psel, penable}, 32'h2);
        chk(paddr == a, "R1 paddr", paddr, a);
        chk(pwrite == w, "R1 pwrite", {31'b0, pwrite}, {31'b0, w});
        chk(pwdata == exp_wd, "R1 pwdata", pwdata, exp_wd);
        @(negedge clk);
        chk(psel && penable, "R2 access phase", {30'b0, psel, penable}, 32'h3);
        n = 0;
        while (psel && penable && n < 20) begin
            n++;
            chk(paddr == a && pwdata == exp_wd && pwrite == w, "R3 stable", paddr, a);
            @(negedge clk);
        end
        chk(n == ws + 1, "R3 access length", n, ws + 1);
        chk(!psel && !penable, "R4 release", {30'b0, psel, penable}, 32'h0);
        chk(rsp_valid, "R5 rsp_valid", {31'b0, rsp_valid}, 32'h1);
        chk(rsp_rdata == (w ? 32'h0 : tgt_data(a)), "R5 rsp_rdata", rsp_rdata, w ? 32'h0 : tgt_data(a));
        chk(rsp_err == e, "R5 rsp_err", {31'b0, rsp_err}, {31'b0, e});
        cnt = 0;
        while (!cmd_ready && cnt < 20) begin
            cnt++;
            chk(!psel, "R6 no transfer in gap", {31'b0, psel}, 32'h0);
            cmd_addr = 32'hDEAD_0000; cmd_valid = 1'b1;
            @(negedge clk);
            if (cnt == 1) chk(!rsp_valid, "R5 single cycle", {31'b0, rsp_valid}, 32'h0);
        end
        cmd_valid = 1'b0;
        chk(cnt == exp_g, "R7 gap length", cnt, exp_g);
        if (cnt == 0) begin
            @(negedge clk);
            chk(!rsp_valid, "R5 single cycle", {31'b0, rsp_valid}, 32'h0);
        end
        chk(!psel, "R6 ignored during gap", {31'b0, psel}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!psel && !penable, "R8 reset bus idle", {30'b0, psel, penable}, 32'h0);
        chk(cmd_ready && !rsp_valid, "R8 reset ready", {30'b0, cmd_ready, rsp_valid}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);
        for (int g = 0; g < 8; g++)
            for (int ws = 0; ws < 4; ws++)
                for (int w = 0; w < 2; w++)
                    for (int e = 0; e < 2; e++) begin
                        logic [31:0] a;
                        a = 32'h4000_0000 + (g << 12) + (ws << 8) + (w << 4) + (e << 2);
                        do_xfer(a, w[0], ~a, g, ws, e[0]);
                    end
        // reset in the middle of an access phase
        tgt_ws = 3;
        cmd_addr = 32'h1234_5678; cmd_write = 1'b0; cmd_gap = 3'd2; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(!psel && !penable, "R8 abort transfer", {30'b0, psel, penable}, 32'h0);
        chk(cmd_ready, "R8 ready in reset", {31'b0, cmd_ready}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!psel && cmd_ready && !rsp_valid, "R8 idle after reset", {30'b0, psel, cmd_ready}, 32'h1);
        do_xfer(32'h0000_00F0, 1'b1, 32'hCAFE_F00D, 1, 0, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule